// File: doc/BRIEF.md
# Serial Receiver with Flag-Tagged Byte Queue

The block is the receive half of an asynchronous serial port. It oversamples the incoming line with a strobe that pulses sixteen times per bit. It checks the start bit at its middle and assembles a frame from the configured data length and parity mode. Each finished character goes into a sixteen-entry queue. The parity-error, framing-error and line-break flags of that character are stored in the same entry, so they leave the queue together with the byte they describe.

The host reads the entry at the head of the queue through dedicated outputs and removes it with a one-cycle `pop` strobe. The block reports the fill level and raises a sticky request when the fill reaches a selectable threshold. It raises a sticky idle-timeout request when characters wait in an otherwise silent line. It records a queue overflow, and it drives a flow-control output that tells the far end to stop sending when the queue fills past a programmable level. A soft reset request returns everything to its reset state over a short fixed window.

The receive state machine has six states. `RX_IDLE` moves to `RX_START` on a low sample at a tick. `RX_START` returns to `RX_IDLE` if the mid-bit sample is high (a false start), and otherwise moves to `RX_DATA`. `RX_DATA` moves after the last data bit to `RX_PARITY` when parity is enabled, or to `RX_STOP` when it is not. `RX_PARITY` moves to `RX_STOP`. `RX_STOP` moves to `RX_IDLE` on a high stop sample, or to `RX_HOLD` on a low one. `RX_HOLD` moves to `RX_IDLE` once the line is high again.

Top module: `serial_rx_unit`

## Requirements
- R1: The queue holds 16 entries and `fill` gives the count (0 to 16). A character that completes while the queue is full is dropped, and the queue contents stay unchanged. In that case `overrun` sets and stays set until a `clr_ovr` strobe.
- R2: A frame starts on a low line sample taken at a tick. The start is accepted only if the line is still low 8 ticks later; otherwise the receiver returns to idle and stores nothing. Data bits are sampled every 16 ticks after that point, least significant bit first.
- R3: With `cfg_seven_bit` = 1, seven data bits are received and bit 7 of the stored byte is 0. With `cfg_seven_bit` = 0, eight data bits are received.
- R4: With `cfg_par_en` = 1, one parity bit follows the data. The entry's parity flag is set when the count of ones in the data and parity bits is odd for `cfg_par_even` = 1, or even for `cfg_par_even` = 0.
- R5: A low sample in the stop-bit position sets the entry's framing flag.
- R6: When all data bits, any parity bit and the stop bit are low, the entry is stored as byte 0x00 with the break flag set and the framing and parity flags clear. No further frame starts until the line has returned high, so a long break yields exactly one entry.
- R7: `head_data`, `head_brk`, `head_fer` and `head_per` show the oldest entry. Each `pop` removes that entry, and entries leave in arrival order.
- R8: `no_data` is 1 exactly when the queue is empty.
- R9: `rx_stat` sets when `fill` is at or above the threshold selected by `cfg_thresh_sel` (0, 1, 2, 3 select 1, 4, 8, 12 entries). It stays set until a `clr_rx_stat` strobe. If the threshold condition still holds in the cycle of the strobe, the set wins.
- R10: `tout_stat` sets when the queue is non-empty and the receiver has sat idle for 4 character times. A character time is 16 ticks per bit of the configured frame, counting start bit, data bits, parity bit and one stop bit. `tout_stat` stays set until a `clr_tout` strobe.
- R11: `flush_req` empties the queue only when `flush_en` is 1 in the same cycle. It has no effect otherwise.
- R12: With `cfg_rts_hw_en` = 1, `rts_ok` is 0 while `fill` is at or above `cfg_rts_level`, and 1 otherwise, one cycle after the fill changes. With `cfg_rts_hw_en` = 0, `rts_ok` is 1.
- R13: A `sw_rst_req` strobe makes `sw_rst_busy` go high for 4 cycles. During that window the queue, all sticky requests and the receiver return to their reset state, and `sw_rst_busy` then drops by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial line input, idle high |
| cfg_seven_bit | input | 1 | 1 selects seven data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 selects even parity, 0 odd |
| cfg_thresh_sel | input | 2 | Threshold code: 1, 4, 8 or 12 entries |
| cfg_rts_level | input | 4 | Fill level that stops the far end |
| cfg_rts_hw_en | input | 1 | Flow-control output follows fill level |
| pop | input | 1 | Remove head entry |
| flush_req | input | 1 | Empty the queue (needs flush_en) |
| flush_en | input | 1 | Qualifier for flush_req |
| clr_rx_stat | input | 1 | Clear threshold request |
| clr_tout | input | 1 | Clear timeout request |
| clr_ovr | input | 1 | Clear overflow flag |
| sw_rst_req | input | 1 | Soft reset request strobe |
| head_data | output | 8 | Byte at queue head |
| head_brk | output | 1 | Head entry is a break |
| head_fer | output | 1 | Head entry framing error |
| head_per | output | 1 | Head entry parity error |
| no_data | output | 1 | Queue empty |
| fill | output | 5 | Entries in queue |
| rx_stat | output | 1 | Sticky threshold request |
| tout_stat | output | 1 | Sticky idle-timeout request |
| overrun | output | 1 | Sticky overflow flag |
| rts_ok | output | 1 | 1 lets the far end send |
| sw_rst_busy | output | 1 | Soft reset in progress |

## Verification
A receiver that leaves `RX_START` at the wrong time, or samples off-centre, shows up at `head_data` as a shifted byte within one frame. A spurious or missing flag shows up on the entry itself. A stuck `RX_HOLD` shows up as a missing entry for the next character. Queue pointer or count faults show up at `fill`, at `no_data` and in the pop order within a few pops. Timeout counter faults move the `tout_stat` edge across a window that is checked both just before and just after the expected four-character point.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       fer;
        logic       per;
        logic [7:0] data;
    } rx_entry_t;

    // threshold code to entry count
    function automatic int thresh_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_fsm.sv
module rx_line_fsm
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      srst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      seven_bit,
    input  logic      par_en,
    input  logic      par_even,
    output logic      push,
    output rx_entry_t push_entry,
    output logic      line_idle
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    rx_state_e state_q, state_d;
    logic [1:0]    sync_q;
    logic          rx;
    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    shreg_q;
    logic          pbit_q;
    logic          mid_pt, full_pt, last_bit;
    logic          par_bad, is_brk;

    assign rx       = sync_q[1];
    assign mid_pt   = tick && (cnt_q == CW'(HALF - 1));
    assign full_pt  = tick && (cnt_q == CW'(OVS - 1));
    assign last_bit = (bit_q == (seven_bit ? 3'd6 : 3'd7));
    assign par_bad  = par_en && ((^shreg_q ^ pbit_q) == par_even);
    assign is_brk   = !rx && (shreg_q == 8'h00) && (!par_en || !pbit_q);

    // input synchroniser
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sync_q <= 2'b11;
        else if (srst) sync_q <= 2'b11;
        else           sync_q <= {sync_q[0], rxd};
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !rx) state_d = RX_START;
            RX_START:  if (mid_pt) state_d = rx ? RX_IDLE : RX_DATA;
            RX_DATA:   if (full_pt && last_bit) state_d = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (full_pt) state_d = RX_STOP;
            RX_STOP:   if (full_pt) state_d = rx ? RX_IDLE : RX_HOLD;
            RX_HOLD:   if (rx) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= RX_IDLE;
        else if (srst) state_q <= RX_IDLE;
        else           state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            bit_q      <= '0;
            shreg_q    <= '0;
            pbit_q     <= 1'b0;
            push       <= 1'b0;
            push_entry <= '0;
        end else if (srst) begin
            cnt_q      <= '0;
            bit_q      <= '0;
            shreg_q    <= '0;
            pbit_q     <= 1'b0;
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            push <= 1'b0;
            unique case (state_q)
                RX_IDLE, RX_HOLD: begin
                    cnt_q   <= '0;
                    bit_q   <= '0;
                    shreg_q <= '0;
                    pbit_q  <= 1'b0;
                end
                RX_START: begin
                    if (tick) cnt_q <= mid_pt ? '0 : cnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (tick) cnt_q <= cnt_q + 1'b1;
                    if (full_pt) begin
                        shreg_q[bit_q] <= rx;
                        bit_q          <= bit_q + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (tick) cnt_q <= cnt_q + 1'b1;
                    if (full_pt) pbit_q <= rx;
                end
                RX_STOP: begin
                    if (tick) cnt_q <= cnt_q + 1'b1;
                    if (full_pt) begin
                        push <= 1'b1;
                        if (is_brk) begin
                            push_entry <= '{brk: 1'b1, fer: 1'b0, per: 1'b0, data: 8'h00};
                        end else begin
                            push_entry <= '{brk: 1'b0, fer: !rx, per: par_bad, data: shreg_q};
                        end
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign line_idle = (state_q == RX_IDLE);

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import serial_rx_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             clear,
    input  logic             push,
    input  rx_entry_t        push_entry,
    input  logic             pop,
    output rx_entry_t        head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             overflow
);
    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          full, do_push, do_pop;

    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign do_pop   = pop && !empty;
    assign do_push  = push && (!full || do_pop);
    assign overflow = push && full && !do_pop;
    assign head     = mem[rd_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else if (srst || clear) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !srst && !clear) mem[wr_q] <= push_entry;
    end

endmodule

// File: rtl/rx_status_ctl.sv
module rx_status_ctl
    import serial_rx_pkg::*;
#(
    parameter  int OVS   = 16,
    parameter  int CNT_W = 5,
    localparam int TO_W  = $clog2(4 * OVS * 11 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic             empty,
    input  logic             line_idle,
    input  logic             overflow,
    input  logic             seven_bit,
    input  logic             par_en,
    input  logic [1:0]       thresh_sel,
    input  logic [3:0]       rts_level,
    input  logic             rts_hw_en,
    input  logic             clr_rx_stat,
    input  logic             clr_tout,
    input  logic             clr_ovr,
    output logic             rx_stat,
    output logic             tout_stat,
    output logic             overrun,
    output logic             rts_ok
);
    logic [TO_W-1:0] idle_q;
    logic [TO_W-1:0] to_limit;
    logic            at_thresh, rts_stop, to_hit;

    always_comb begin
        int frame_bits;
        frame_bits = 2 + (seven_bit ? 7 : 8) + (par_en ? 1 : 0);
        to_limit   = TO_W'(4 * OVS * frame_bits);
    end

    assign at_thresh = (count >= CNT_W'(thresh_level(thresh_sel)));
    assign rts_stop  = rts_hw_en && (count >= CNT_W'(rts_level));
    assign to_hit    = tick && !empty && line_idle && (idle_q == to_limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q    <= '0;
            rx_stat   <= 1'b0;
            tout_stat <= 1'b0;
            overrun   <= 1'b0;
            rts_ok    <= 1'b1;
        end else if (srst) begin
            idle_q    <= '0;
            rx_stat   <= 1'b0;
            tout_stat <= 1'b0;
            overrun   <= 1'b0;
            rts_ok    <= 1'b1;
        end else begin
            if (empty || !line_idle)                 idle_q <= '0;
            else if (tick && (idle_q != to_limit))   idle_q <= idle_q + 1'b1;
            rx_stat   <= (rx_stat & ~clr_rx_stat) | at_thresh;
            tout_stat <= (tout_stat & ~clr_tout) | to_hit;
            overrun   <= (overrun & ~clr_ovr) | overflow;
            rts_ok    <= !rts_stop;
        end
    end

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter  int DEPTH    = 16,
    parameter  int OVS      = 16,
    parameter  int RST_HOLD = 4,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int RH_W     = $clog2(RST_HOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rxd,
    input  logic             cfg_seven_bit,
    input  logic             cfg_par_en,
    input  logic             cfg_par_even,
    input  logic [1:0]       cfg_thresh_sel,
    input  logic [3:0]       cfg_rts_level,
    input  logic             cfg_rts_hw_en,
    input  logic             pop,
    input  logic             flush_req,
    input  logic             flush_en,
    input  logic             clr_rx_stat,
    input  logic             clr_tout,
    input  logic             clr_ovr,
    input  logic             sw_rst_req,
    output logic [7:0]       head_data,
    output logic             head_brk,
    output logic             head_fer,
    output logic             head_per,
    output logic             no_data,
    output logic [CNT_W-1:0] fill,
    output logic             rx_stat,
    output logic             tout_stat,
    output logic             overrun,
    output logic             rts_ok,
    output logic             sw_rst_busy
);
    logic [RH_W-1:0] rh_q;
    logic            srst;
    logic            push, line_idle, empty, overflow;
    rx_entry_t       push_entry, head;

    // soft reset window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               rh_q <= '0;
        else if (sw_rst_req)      rh_q <= RH_W'(RST_HOLD);
        else if (rh_q != '0)      rh_q <= rh_q - 1'b1;
    end
    assign sw_rst_busy = (rh_q != '0);
    assign srst        = sw_rst_busy;

    rx_line_fsm #(.OVS(OVS)) line_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst),
        .tick       (tick16),
        .rxd        (rxd),
        .seven_bit  (cfg_seven_bit),
        .par_en     (cfg_par_en),
        .par_even   (cfg_par_even),
        .push       (push),
        .push_entry (push_entry),
        .line_idle  (line_idle)
    );

    rx_tag_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst),
        .clear      (flush_req && flush_en),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .count      (fill),
        .empty      (empty),
        .overflow   (overflow)
    );

    rx_status_ctl #(.OVS(OVS), .CNT_W(CNT_W)) stat_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst        (srst),
        .tick        (tick16),
        .count       (fill),
        .empty       (empty),
        .line_idle   (line_idle),
        .overflow    (overflow),
        .seven_bit   (cfg_seven_bit),
        .par_en      (cfg_par_en),
        .thresh_sel  (cfg_thresh_sel),
        .rts_level   (cfg_rts_level),
        .rts_hw_en   (cfg_rts_hw_en),
        .clr_rx_stat (clr_rx_stat),
        .clr_tout    (clr_tout),
        .clr_ovr     (clr_ovr),
        .rx_stat     (rx_stat),
        .tout_stat   (tout_stat),
        .overrun     (overrun),
        .rts_ok      (rts_ok)
    );

    assign head_data = head.data;
    assign head_brk  = head.brk;
    assign head_fer  = head.fer;
    assign head_per  = head.per;
    assign no_data   = empty;

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
    parameter int CNT_W = 5,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_rst_busy,
    input logic [CNT_W-1:0] fill,
    input logic             no_data,
    input logic             head_brk,
    input logic             head_fer,
    input logic             head_per,
    input logic             overrun,
    input logic             clr_ovr,
    input logic             tout_stat,
    input logic             clr_tout,
    input logic             rts_ok,
    input logic             cfg_rts_hw_en,
    input logic [3:0]       cfg_rts_level
);
    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    assert_ovr_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_ovr && !sw_rst_busy) |=> overrun);

    assert_brk_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_data && head_brk) |-> (!head_fer && !head_per));

    assert_nodata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        no_data |-> (fill == '0));

    assert_tout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_stat && !clr_tout && !sw_rst_busy) |=> tout_stat);

    assert_rts_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rts_hw_en && !sw_rst_busy && (fill >= CNT_W'(cfg_rts_level))) |=> !rts_ok);

endmodule

bind serial_rx_unit serial_rx_checker #(.CNT_W(CNT_W), .DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_rst_busy   (sw_rst_busy),
    .fill          (fill),
    .no_data       (no_data),
    .head_brk      (head_brk),
    .head_fer      (head_fer),
    .head_per      (head_per),
    .overrun       (overrun),
    .clr_ovr       (clr_ovr),
    .tout_stat     (tout_stat),
    .clr_tout      (clr_tout),
    .rts_ok        (rts_ok),
    .cfg_rts_hw_en (cfg_rts_hw_en),
    .cfg_rts_level (cfg_rts_level)
);

// File: tb/serial_rx_unit_tb_top.sv
module serial_rx_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BITC       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       rxd = 1'b1;
    logic       cfg_seven_bit = 1'b0, cfg_par_en = 1'b0, cfg_par_even = 1'b0;
    logic [1:0] cfg_thresh_sel = 2'd0;
    logic [3:0] cfg_rts_level = 4'd8;
    logic       cfg_rts_hw_en = 1'b0;
    logic       pop = 1'b0, flush_req = 1'b0, flush_en = 1'b0;
    logic       clr_rx_stat = 1'b0, clr_tout = 1'b0, clr_ovr = 1'b0, sw_rst_req = 1'b0;
    logic [7:0] head_data;
    logic       head_brk, head_fer, head_per, no_data;
    logic [4:0] fill;
    logic       rx_stat, tout_stat, overrun, rts_ok, sw_rst_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_rx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_seven_bit(cfg_seven_bit), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_thresh_sel(cfg_thresh_sel), .cfg_rts_level(cfg_rts_level), .cfg_rts_hw_en(cfg_rts_hw_en),
        .pop(pop), .flush_req(flush_req), .flush_en(flush_en),
        .clr_rx_stat(clr_rx_stat), .clr_tout(clr_tout), .clr_ovr(clr_ovr), .sw_rst_req(sw_rst_req),
        .head_data(head_data), .head_brk(head_brk), .head_fer(head_fer), .head_per(head_per),
        .no_data(no_data), .fill(fill), .rx_stat(rx_stat), .tout_stat(tout_stat),
        .overrun(overrun), .rts_ok(rts_ok), .sw_rst_busy(sw_rst_busy)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    // one frame: data LSB first, optional parity bit, stop bit value
    task automatic send(input logic [7:0] d, input int nbits, input bit has_par,
                        input logic pbit, input logic stopv);
        @(negedge clk); rxd = 1'b0; wait_cyc(BITC - 1);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); rxd = d[i]; wait_cyc(BITC - 1);
        end
        if (has_par) begin
            @(negedge clk); rxd = pbit; wait_cyc(BITC - 1);
        end
        @(negedge clk); rxd = stopv; wait_cyc(BITC - 1);
        @(negedge clk); rxd = 1'b1;
    endtask

    task automatic send8(input logic [7:0] d);
        send(d, 8, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic drain();
        while (fill != 0) strobe(pop);
        strobe(clr_rx_stat); strobe(clr_tout); strobe(clr_ovr);
    endtask

    task automatic t_reset();
        check("R8", "no_data at reset", no_data, 1);
        check("R1", "fill at reset", fill, 0);
        check("R1", "overrun at reset", overrun, 0);
        check("R12", "rts_ok at reset", rts_ok, 1);
        check("R9", "rx_stat at reset", rx_stat, 0);
    endtask

    task automatic t_basic();
        send8(8'hA5); wait_cyc(30);
        check("R2", "byte A5", head_data, 8'hA5);
        check("R7", "flags clean", {head_brk, head_fer, head_per}, 0);
        check("R8", "no_data with one byte", no_data, 0);
        check("R9", "rx_stat at level 1", rx_stat, 1);
        strobe(pop); wait_cyc(1);
        check("R8", "no_data after pop", no_data, 1);
        strobe(clr_rx_stat); wait_cyc(1);
        check("R9", "rx_stat cleared", rx_stat, 0);
    endtask

    task automatic t_seven();
        cfg_seven_bit = 1'b1; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        send(8'h35, 7, 1'b1, 1'b0, 1'b1); wait_cyc(30);
        check("R3", "seven-bit byte", head_data, 8'h35);
        check("R4", "even parity good", head_per, 0);
        drain();
        send(8'h7F, 7, 1'b1, 1'b0, 1'b1); wait_cyc(30);
        check("R3", "bit 7 zero for 7F", head_data, 8'h7F);
        check("R4", "even parity bad", head_per, 1);
        drain();
        cfg_seven_bit = 1'b0; cfg_par_even = 1'b0;
        send(8'h01, 8, 1'b1, 1'b1, 1'b1); wait_cyc(30);
        check("R4", "odd parity bad", head_per, 1);
        drain();
        send(8'h03, 8, 1'b1, 1'b1, 1'b1); wait_cyc(30);
        check("R4", "odd parity good", head_per, 0);
        drain();
        cfg_par_en = 1'b0;
    endtask

    task automatic t_frame();
        send(8'h55, 8, 1'b0, 1'b0, 1'b0); wait_cyc(30);
        check("R5", "framing flag", head_fer, 1);
        check("R5", "framing data", head_data, 8'h55);
        check("R5", "framing not break", head_brk, 0);
        drain();
    endtask

    task automatic t_break();
        cfg_par_en = 1'b1; cfg_par_even = 1'b0;
        @(negedge clk); rxd = 1'b0; wait_cyc(BITC * 14);
        @(negedge clk); rxd = 1'b1; wait_cyc(40);
        check("R6", "one entry for break", fill, 1);
        check("R6", "break entry", {head_brk, head_fer, head_per, head_data}, 11'h400);
        drain();
        cfg_par_en = 1'b0;
    endtask

    task automatic t_glitch();
        @(negedge clk); rxd = 1'b0; wait_cyc(4);
        @(negedge clk); rxd = 1'b1; wait_cyc(BITC * 12);
        check("R2", "false start ignored", fill, 0);
    endtask

    task automatic t_order();
        cfg_thresh_sel = 2'd1;
        send8(8'h11); send8(8'h22); send8(8'h33); wait_cyc(30);
        check("R9", "below level 4", rx_stat, 0);
        send8(8'h44); wait_cyc(30);
        check("R9", "at level 4", rx_stat, 1);
        cfg_thresh_sel = 2'd3; strobe(clr_rx_stat); wait_cyc(2);
        check("R9", "level 12 not reached", rx_stat, 0);
        cfg_rts_hw_en = 1'b1; cfg_rts_level = 4'd4; wait_cyc(2);
        check("R12", "rts stop at 4", rts_ok, 0);
        check("R7", "head first", head_data, 8'h11);
        strobe(pop); wait_cyc(2);
        check("R12", "rts resume at 3", rts_ok, 1);
        check("R7", "head second", head_data, 8'h22);
        strobe(pop); wait_cyc(1);
        check("R7", "head third", head_data, 8'h33);
        cfg_rts_level = 4'd1; wait_cyc(2);
        check("R12", "rts stop at level 1", rts_ok, 0);
        cfg_rts_hw_en = 1'b0; wait_cyc(2);
        check("R12", "rts with hw off", rts_ok, 1);
        @(negedge clk); flush_req = 1'b1; flush_en = 1'b0;
        @(negedge clk); flush_req = 1'b0; wait_cyc(1);
        check("R11", "flush without enable", fill, 2);
        @(negedge clk); flush_req = 1'b1; flush_en = 1'b1;
        @(negedge clk); flush_req = 1'b0; flush_en = 1'b0; wait_cyc(1);
        check("R11", "flush with enable", fill, 0);
        cfg_thresh_sel = 2'd0;
        drain();
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 17; i++) send8(8'(i + 8'h60));
        wait_cyc(30);
        check("R1", "fill full", fill, 16);
        check("R1", "overrun set", overrun, 1);
        check("R1", "oldest kept", head_data, 8'h60);
        strobe(clr_ovr); wait_cyc(1);
        check("R1", "overrun cleared", overrun, 0);
        strobe(sw_rst_req);
        check("R13", "busy during reset", sw_rst_busy, 1);
        wait_cyc(6);
        check("R13", "busy drops", sw_rst_busy, 0);
        check("R13", "queue empty after reset", fill, 0);
        check("R13", "rx_stat after reset", rx_stat, 0);
    endtask

    task automatic t_timeout();
        strobe(clr_tout);
        send8(8'h5A); wait_cyc(560);
        check("R10", "no timeout before 4 chars", tout_stat, 0);
        wait_cyc(120);
        check("R10", "timeout after 4 chars", tout_stat, 1);
        wait_cyc(20);
        check("R10", "timeout sticky", tout_stat, 1);
        strobe(clr_tout); wait_cyc(1);
        check("R10", "timeout cleared", tout_stat, 0);
        drain();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_basic();
        t_seven();
        t_frame();
        t_break();
        t_glitch();
        t_order();
        t_overrun();
        t_timeout();
        finish_run();
    end

endmodule